// File: doc/BRIEF.md
# Fully Associative Tag Lookup

This block is the tag side of a fully associative cache. It keeps a tag, a valid bit and a dirty bit for each of a parameterised number of slots, and any memory block may sit in any slot. There is no index field: the whole block address is the tag. Each request tag is compared against every slot at the same time, and a priority encoder turns the match vector into a slot number. The data array and the transfers to and from memory sit outside this block.

The lookup is combinational. With `req_valid` high, `hit`, `hit_slot`, `hit_dirty`, `multi_hit` and `byte_off` follow `req_addr` in the same cycle. The block always nominates a slot for the next incoming block, using the lowest free slot or, when every slot is full, a rotating pointer. It also reports whether that slot holds modified data that must be written back first. The cache controller then completes the fill, which writes the tag and updates the state bits at the next clock edge. A write request that hits marks its slot dirty. A flush empties the whole store in one cycle.

Top module: `fa_tag_lookup`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) every slot is invalid and clean, `hit` and `victim_wb` are 0, and `victim_slot` is 0.
- R2: With `req_valid` high, `hit` is 1 in the same cycle when a valid slot holds the tag `req_addr[ADDR_W-1:OFF_W]`. `hit_slot` then gives that slot's number, and `byte_off` always equals `req_addr[OFF_W-1:0]`. With `req_valid` low, `hit` is 0.
- R3: A slot whose valid bit is 0 never matches, even when its stored tag equals the request tag. A request tag that no valid slot holds gives `hit` = 0.
- R4: When more than one valid slot matches, `hit_slot` gives the lowest-numbered of them and `multi_hit` is 1. With a single match `multi_hit` is 0.
- R5: While any slot is invalid, `victim_slot` is the lowest-numbered invalid slot.
- R6: While every slot is valid, `victim_slot` is the rotating pointer. The pointer starts at 0 after reset and steps by one, wrapping from SLOTS-1 to 0, after every accepted fill.
- R7: A fill (`fill_valid` high at a clock edge) stores `fill_tag` in slot `fill_slot`, sets its valid bit and sets its dirty bit to `fill_write`. The new state is visible from the next cycle, and `hit_dirty` reports the dirty bit of the slot reported by `hit_slot`.
- R8: A request with `req_valid` and `req_write` high that hits sets the matched slot's dirty bit at the clock edge. A read hit leaves the dirty bit unchanged.
- R9: `victim_wb` is 1 exactly when the nominated slot is both valid and dirty, and `victim_tag` gives that slot's stored tag.
- R10: `flush` high at a clock edge clears every valid and dirty bit and returns the rotating pointer to 0. A fill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots, reset the rotating pointer |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | Request is a write; a hit marks the slot dirty |
| hit | output | 1 | A valid slot holds the request tag |
| hit_slot | output | IDX_W | Lowest matching slot |
| byte_off | output | OFF_W | Byte position within the block |
| hit_dirty | output | 1 | Dirty bit of the matching slot |
| multi_hit | output | 1 | More than one slot matched (error) |
| victim_slot | output | IDX_W | Slot nominated for the next incoming block |
| victim_wb | output | 1 | Nominated slot holds modified data |
| victim_tag | output | TAG_W | Tag stored in the nominated slot |
| fill_valid | input | 1 | Fill completes this cycle |
| fill_slot | input | IDX_W | Slot being filled |
| fill_tag | input | TAG_W | Tag written by the fill |
| fill_write | input | 1 | Fill serves a write; the slot starts dirty |

## Verification
The assertions assume that `fill_slot` names a slot inside the array, and that a fill and a write hit never make claims about the same dirty bit in conflicting ways. They also assume that a tag already present is only refilled on purpose. The stimulus fills only the slots the block nominates, except for one case that stores a duplicate tag to provoke a multi-hit and one that fills an out-of-order slot after a flush to create a hole below a valid slot. Inputs change only on the falling edge, so every combinational lookup is settled before it is sampled and before the next rising edge.

// File: rtl/fa_tag_pkg.sv
package fa_tag_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_OFF_W  = 5;
    localparam int unsigned DEF_SLOTS  = 8;

    // wrapping increment of a slot number
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int unsigned TAG_W = 27,
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]            valid_i,
    input  logic [SLOTS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]            req_tag,
    output logic                        any_o,
    output logic                        multi_o,
    output logic [IDX_W-1:0]            first_o
);

    logic [SLOTS-1:0] match_vec;

    // one comparator per slot, all in parallel
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
            assign match_vec[s] = valid_i[s] && (tags_i[s] == req_tag);
        end
    endgenerate

    // priority encoder: lowest slot wins
    always_comb begin
        first_o = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (match_vec[s]) first_o = IDX_W'(s);
        end
    end

    assign any_o   = |match_vec;
    assign multi_o = (match_vec & (match_vec - 1'b1)) != '0;

endmodule

// File: rtl/fa_tag_alloc.sv
module fa_tag_alloc #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] valid_i,
    input  logic [IDX_W-1:0] rr_i,
    output logic [IDX_W-1:0] victim_o
);

    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!valid_i[s]) free_idx = IDX_W'(s);
        end
    end

    assign any_free = ~&valid_i;
    assign victim_o = any_free ? free_idx : rr_i;

endmodule

// File: rtl/fa_tag_lookup.sv
module fa_tag_lookup
    import fa_tag_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned SLOTS  = DEF_SLOTS,
    localparam int unsigned TAG_W = ADDR_W - OFF_W,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_slot,
    output logic [OFF_W-1:0]  byte_off,
    output logic              hit_dirty,
    output logic              multi_hit,
    output logic [IDX_W-1:0]  victim_slot,
    output logic              victim_wb,
    output logic [TAG_W-1:0]  victim_tag,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_slot,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_write
);

    logic [SLOTS-1:0]            valid_q;
    logic [SLOTS-1:0]            dirty_q;
    logic [SLOTS-1:0][TAG_W-1:0] tag_q;
    logic [IDX_W-1:0]            rr_q;

    logic [TAG_W-1:0] req_tag;
    logic             any_match;
    logic             fill_ok;

    assign req_tag  = req_addr[ADDR_W-1:OFF_W];
    assign byte_off = req_addr[OFF_W-1:0];
    assign fill_ok  = fill_valid && !flush;

    fa_tag_match #(.TAG_W(TAG_W), .SLOTS(SLOTS)) u_match (
        .valid_i (valid_q),
        .tags_i  (tag_q),
        .req_tag (req_tag),
        .any_o   (any_match),
        .multi_o (multi_hit),
        .first_o (hit_slot)
    );

    assign hit       = req_valid && any_match;
    assign hit_dirty = hit && dirty_q[hit_slot];

    fa_tag_alloc #(.SLOTS(SLOTS)) u_alloc (
        .valid_i  (valid_q),
        .rr_i     (rr_q),
        .victim_o (victim_slot)
    );

    assign victim_wb  = valid_q[victim_slot] && dirty_q[victim_slot];
    assign victim_tag = tag_q[victim_slot];

    // state bits and rotating pointer
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
            dirty_q <= '0;
            rr_q    <= '0;
        end else begin
            if (fill_valid) begin
                valid_q[fill_slot] <= 1'b1;
                dirty_q[fill_slot] <= fill_write;
                rr_q               <= IDX_W'(wrap_inc(rr_q, SLOTS));
            end
            if (hit && req_write) begin
                dirty_q[hit_slot] <= 1'b1;
            end
        end
    end

    // tag array carries no reset; valid bits qualify it
    always_ff @(posedge clk) begin
        if (!rst && fill_ok) begin
            tag_q[fill_slot] <= fill_tag;
        end
    end

    // R4
    multihit_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && multi_hit) |-> hit);

    // R5
    victim_is_free_chk: assert property (@(posedge clk) disable iff (rst)
        (~&valid_q) |-> !valid_q[victim_slot]);

    // R6
    victim_rotates_chk: assert property (@(posedge clk) disable iff (rst)
        (&valid_q) |-> (victim_slot == rr_q));

    // R7
    fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fill_ok |=> valid_q[$past(fill_slot)]);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0 && rr_q == '0));

    // R9
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (dirty_q & ~valid_q) == '0);

endmodule

// File: tb/fa_tag_lookup_tb.sv
module fa_tag_lookup_tb;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFF_W  = 5;
    localparam int unsigned SLOTS  = 8;
    localparam int unsigned TAG_W  = ADDR_W - OFF_W;
    localparam int unsigned IDX_W  = $clog2(SLOTS);

    logic              clk = 1'b0;
    logic              rst, flush, req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic              hit, hit_dirty, multi_hit, victim_wb;
    logic [IDX_W-1:0]  hit_slot, victim_slot;
    logic [OFF_W-1:0]  byte_off;
    logic [TAG_W-1:0]  victim_tag;
    logic              fill_valid, fill_write;
    logic [IDX_W-1:0]  fill_slot;
    logic [TAG_W-1:0]  fill_tag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fa_tag_lookup #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SLOTS(SLOTS)) u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .hit(hit), .hit_slot(hit_slot), .byte_off(byte_off),
        .hit_dirty(hit_dirty), .multi_hit(multi_hit),
        .victim_slot(victim_slot), .victim_wb(victim_wb), .victim_tag(victim_tag),
        .fill_valid(fill_valid), .fill_slot(fill_slot),
        .fill_tag(fill_tag), .fill_write(fill_write)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int off);
        return {TAG_W'(tag), OFF_W'(off)};
    endfunction

    // settle a read lookup in the low phase
    task automatic look(input int tag, input int off);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(tag, off);
        #2;
    endtask

    task automatic idle_req();
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_fill(input int slot, input int tag, input bit wr, input bit with_flush);
        @(negedge clk);
        idle_req();
        fill_valid = 1'b1; fill_slot = IDX_W'(slot); fill_tag = TAG_W'(tag);
        fill_write = wr; flush = with_flush;
        @(posedge clk);
        #1;
        fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        look(0, 0);
        chk(hit, 0, "R1 hit after reset (stale tag 0)");
        chk(victim_slot, 0, "R1 victim slot after reset");
        chk(victim_wb, 0, "R1 victim write-back after reset");
        idle_req();
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < SLOTS; i++) begin
            @(negedge clk); #1;
            chk(victim_slot, i, "R5 lowest free slot nominated");
            do_fill(i, 100 + i, (i == 3), 1'b0);
        end
        for (int i = 0; i < SLOTS; i++) begin
            look(100 + i, i + 1);
            chk(hit, 1, "R2 hit on filled slot");
            chk(hit_slot, i, "R2 hit slot number");
            chk(byte_off, i + 1, "R2 byte offset");
            chk(hit_dirty, (i == 3), "R7 dirty follows fill_write");
            chk(multi_hit, 0, "R4 single match has no multi flag");
        end
        @(negedge clk);
        idle_req();
        #2 chk(hit, 0, "R2 no hit without req_valid");
    endtask

    task automatic t_rotate();
        look(999, 0);
        chk(hit, 0, "R3 absent tag misses");
        chk(victim_slot, 0, "R6 pointer wrapped to 0 after eight fills");
        chk(victim_wb, 0, "R9 clean victim needs no write-back");
        do_fill(0, 200, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk(victim_slot, 1, "R6 pointer advanced to 1");
        do_fill(1, 201, 1'b0, 1'b0);
        do_fill(2, 202, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk(victim_slot, 3, "R6 pointer advanced to 3");
        chk(victim_wb, 1, "R9 dirty victim flagged");
        chk(victim_tag, 103, "R9 victim tag");
        look(100, 0);
        chk(hit, 0, "R7 replaced tag no longer hits");
        look(200, 0);
        chk(hit_slot, 0, "R7 new tag hits slot 0");
        idle_req();
    endtask

    task automatic t_write_hit();
        look(105, 0);
        @(posedge clk); #1;
        look(105, 0);
        chk(hit_dirty, 0, "R8 read hit leaves slot clean");
        look(104, 0);
        chk(hit_dirty, 0, "R8 slot 4 clean before write");
        req_write = 1'b1;
        @(posedge clk); #1;
        look(104, 0);
        chk(hit_dirty, 1, "R8 write hit marks dirty");
        idle_req();
    endtask

    task automatic t_multi();
        do_fill(3, 104, 1'b0, 1'b0);
        look(104, 7);
        chk(hit, 1, "R4 duplicate tag hits");
        chk(hit_slot, 3, "R4 lowest duplicate reported");
        chk(multi_hit, 1, "R4 multi flag raised");
        idle_req();
    endtask

    task automatic t_flush();
        do_fill(5, 555, 1'b1, 1'b1);
        look(555, 0);
        chk(hit, 0, "R10 fill discarded under flush");
        look(104, 0);
        chk(hit, 0, "R3 stale tag in invalid slot misses");
        chk(victim_slot, 0, "R10 store empty after flush");
        chk(victim_wb, 0, "R10 dirty cleared by flush");
        do_fill(0, 7, 1'b0, 1'b0);
        do_fill(5, 8, 1'b0, 1'b0);
        @(negedge clk); #1;
        chk(victim_slot, 1, "R5 hole below valid slot chosen");
        look(8, 0);
        chk(hit_slot, 5, "R7 out-of-order fill hits");
        idle_req();
        for (int i = 0; i < SLOTS; i++) begin
            if (i != 0 && i != 5) do_fill(i, 300 + i, 1'b0, 1'b0);
        end
        @(negedge clk); #1;
        chk(victim_slot, 0, "R6 pointer reset by flush, eight fills since");
    endtask

    initial begin
        rst = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; fill_valid = 1'b0; fill_slot = '0; fill_tag = '0;
        fill_write = 1'b0;
        t_reset();
        t_fill_all();
        t_rotate();
        t_write_hit();
        t_multi();
        t_flush();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule